// File: doc/BRIEF.md
# Rejected-Interrupt Replay Bitmap

This block keeps a record of interrupt sources whose delivery was refused by the downstream presentation logic, so that they can be replayed later. A refused interrupt arrives as a global interrupt number. The block subtracts the configured base offset from it to get a local source number, and marks that source in a bitmap of 32 words of 64 bits each. A 32-bit summary register has one bit per word and marks which words hold any entry.

When a replay request arrives, the block walks through the recorded sources in ascending order and presents each one on a valid/ready channel as a forced retry toward the pending/queued gate. The summary register lets the walk skip empty words. Each source's entry is erased at the moment its retry is issued. Refusals that arrive during a walk are still recorded. A replay request that arrives during a walk is held and starts a fresh walk when the current one ends.

Top module: `reject_replay`

## Requirements
- R1: A reject with global number N records local source L = N − base. L's word is L >> 6 and its bit is L & 63. The retry for it later carries the value L on `retry_src_o`.
- R2: An accepted reject sets its bitmap bit and the summary bit of its word in the next cycle. The next replay then retries that source.
- R3: A reject whose number is below the base, or whose local number is 2048 or more, is ignored. No later replay retries anything because of it.
- R4: A replay request while idle with an empty summary starts no walk and produces no retry.
- R5: A walk retries sources in ascending local number: words in ascending order, skipping words whose summary bit is clear, and bits 0 to 63 ascending within a word.
- R6: Each recorded source is retried once per walk. Its entry is erased when the retry is issued, so a second replay with no new rejects produces no retry.
- R7: While `retry_valid_o` is high and `retry_ready_i` is low, the valid stays high and `retry_src_o` holds its value. A retry completes on a cycle where both are high.
- R8: A reject that arrives during a walk is recorded. If its source number is above the last retried source, it is retried in the same walk. If it lies in a word already passed, it waits for the next replay.
- R9: A replay request received during a walk is held. When the current walk finishes, a new walk starts from word 0 without a further request.
- R10: Reset clears the bitmap, the summary, any held request and the retry channel. Sources recorded before reset are never retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | GNUM_W | Global number of local source 0 |
| rej_valid_i | input | 1 | Reject event strobe |
| rej_num_i | input | GNUM_W | Global interrupt number of the reject |
| resend_req_i | input | 1 | Replay request strobe |
| retry_valid_o | output | 1 | Forced retry offered |
| retry_src_o | output | 11 | Local source number of the offered retry |
| retry_ready_i | input | 1 | Downstream accepts the retry |

## Verification
A corrupted bitmap or summary bit shows up at the ports as a retry that is missing, extra or out of order. This appears on the first replay after the fault, as soon as the walk reaches the affected word. A bad walk pointer appears as a retry whose number is not the next recorded source above the previous one, visible on that retry's first valid cycle. A lost held request or a lost late reject only becomes visible as a wrong retry count once the walk runs quiet.

// File: rtl/reject_replay.sv
module reject_replay #(
  parameter int GNUM_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter int WORD_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GNUM_W-1:0]     base_i,
  input  logic                  rej_valid_i,
  input  logic [GNUM_W-1:0]     rej_num_i,
  input  logic                  resend_req_i,
  output logic                  retry_valid_o,
  output logic [$clog2(NUM_WORDS*WORD_BITS)-1:0] retry_src_o,
  input  logic                  retry_ready_i
);
  localparam int TOTAL = NUM_WORDS * WORD_BITS;
  localparam int WI_W  = $clog2(NUM_WORDS);
  localparam int BI_W  = $clog2(WORD_BITS);
  localparam int SRC_W = WI_W + BI_W;

  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_WORD, ST_WAIT} st_t;

  st_t                  st;
  logic [WI_W:0]        wptr;
  logic [BI_W:0]        bptr;
  logic                 pend;
  logic [NUM_WORDS-1:0] summary;
  logic [WORD_BITS-1:0] bitmap [NUM_WORDS];

  logic [GNUM_W-1:0] rej_local;
  logic              rej_ok;
  logic [WI_W-1:0]   rej_w;
  logic [BI_W-1:0]   rej_b;

  assign rej_local = rej_num_i - base_i;
  assign rej_ok    = rej_valid_i && (rej_num_i >= base_i) && (rej_local < GNUM_W'(TOTAL));
  assign rej_w     = rej_local[SRC_W-1:BI_W];
  assign rej_b     = rej_local[BI_W-1:0];

  logic            pick_hit;
  logic [WI_W-1:0] pick_idx;
  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = NUM_WORDS - 1; i >= 0; i--)
      if (summary[i] && ((WI_W+1)'(i) >= wptr)) begin
        pick_hit = 1'b1;
        pick_idx = WI_W'(i);
      end
  end

  logic [WORD_BITS-1:0] cur_word;
  logic                 bit_hit;
  logic [BI_W-1:0]      bit_idx;
  assign cur_word = bitmap[wptr[WI_W-1:0]];
  always_comb begin
    bit_hit = 1'b0;
    bit_idx = '0;
    for (int j = WORD_BITS - 1; j >= 0; j--)
      if (cur_word[j] && ((BI_W+1)'(j) >= bptr)) begin
        bit_hit = 1'b1;
        bit_idx = BI_W'(j);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      wptr          <= '0;
      bptr          <= '0;
      pend          <= 1'b0;
      summary       <= '0;
      retry_valid_o <= 1'b0;
      retry_src_o   <= '0;
      for (int k = 0; k < NUM_WORDS; k++) bitmap[k] <= '0;
    end else begin
      if (st != ST_IDLE && resend_req_i) pend <= 1'b1;
      case (st)
        ST_IDLE:
          if (resend_req_i && summary != '0) begin
            wptr <= '0;
            st   <= ST_PICK;
          end
        ST_PICK:
          if (pick_hit) begin
            summary[pick_idx] <= 1'b0;
            wptr <= {1'b0, pick_idx};
            bptr <= '0;
            st   <= ST_WORD;
          end else if (pend || resend_req_i) begin
            pend <= 1'b0;
            wptr <= '0;
          end else begin
            st <= ST_IDLE;
          end
        ST_WORD:
          if (bit_hit) begin
            bitmap[wptr[WI_W-1:0]][bit_idx] <= 1'b0;
            retry_valid_o <= 1'b1;
            retry_src_o   <= {wptr[WI_W-1:0], bit_idx};
            bptr <= {1'b0, bit_idx} + 1'b1;
            st   <= ST_WAIT;
          end else begin
            wptr <= wptr + 1'b1;
            st   <= ST_PICK;
          end
        ST_WAIT:
          if (retry_ready_i) begin
            retry_valid_o <= 1'b0;
            st <= ST_WORD;
          end
        default: st <= ST_IDLE;
      endcase
      if (rej_ok) begin
        bitmap[rej_w][rej_b] <= 1'b1;
        summary[rej_w]       <= 1'b1;
      end
    end
  end

  // R7
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid_o && !retry_ready_i |=> retry_valid_o && $stable(retry_src_o));

  // R2
  rej_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_ok |=> summary[$past(rej_w)] && bitmap[$past(rej_w)][$past(rej_b)]);

  // R3
  rej_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid_i && !rej_ok && st == ST_IDLE |=> $stable(summary));

  // R4
  empty_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE && resend_req_i && summary == '0 |=> st == ST_IDLE && !retry_valid_o);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !retry_valid_o && summary == '0);
endmodule

// File: tb/reject_replay_tb.sv
module reject_replay_tb_top;
  localparam int BASE = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = 32'(BASE);
  logic        rej_valid_i = 1'b0;
  logic [31:0] rej_num_i = '0;
  logic        resend_req_i = 1'b0;
  logic        retry_valid_o;
  logic [10:0] retry_src_o;
  logic        retry_ready_i = 1'b1;

  always #5 clk = ~clk;

  reject_replay dut_i (
    .clk(clk), .rst_n(rst_n), .base_i(base_i),
    .rej_valid_i(rej_valid_i), .rej_num_i(rej_num_i),
    .resend_req_i(resend_req_i),
    .retry_valid_o(retry_valid_o), .retry_src_o(retry_src_o),
    .retry_ready_i(retry_ready_i)
  );

  int checks = 0, fails = 0, nret = 0, last_src = -1;
  bit mb [2048];
  bit seen = 0, pv = 0, pr = 0;
  logic [10:0] ps = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt();
    for (int i = last_src + 1; i < 2048; i++) if (mb[i]) return i;
    for (int i = 0; i < 2048; i++) if (mb[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) chk(retry_valid_o && retry_src_o == ps, "R7 hold", int'(retry_src_o), int'(ps));
      if (retry_valid_o && !seen) begin
        int e;
        e = nxt();
        chk(e >= 0 && int'(retry_src_o) == e, "R5/R1 retry order", int'(retry_src_o), e);
        mb[retry_src_o] = 0;
        last_src = int'(retry_src_o);
        nret++;
      end
      seen = retry_valid_o && !retry_ready_i;
      pv = retry_valid_o; pr = retry_ready_i; ps = retry_src_o;
    end else begin
      seen = 0; pv = 0;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic reject(input int n);
    rej_valid_i = 1'b1; rej_num_i = 32'(n);
    tick();
    rej_valid_i = 1'b0;
    if (n >= BASE && n - BASE < 2048) mb[n - BASE] = 1;
  endtask

  task automatic resend(); resend_req_i = 1'b1; tick(); resend_req_i = 1'b0; endtask

  task automatic quiet();
    int q = 0;
    while (q < 100) begin tick(); if (retry_valid_o) q = 0; else q++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base_cnt;
    repeat (3) tick();
    chk(!retry_valid_o, "R10 reset valid", int'(retry_valid_o), 0);
    rst_n = 1'b1; tick();

    // R4: empty summary
    resend(); repeat (20) tick();
    chk(nret == 0, "R4 empty resend", nret, 0);

    // R1 R2 R5: several words, out of order
    base_cnt = nret;
    reject(BASE + 130); reject(BASE + 5); reject(BASE + 2047); reject(BASE + 64); reject(BASE + 63);
    last_src = -1; resend(); quiet();
    chk(nret - base_cnt == 5, "R2 replay count", nret - base_cnt, 5);

    // R6: second replay empty
    base_cnt = nret; last_src = -1; resend(); quiet();
    chk(nret - base_cnt == 0, "R6 erased after retry", nret - base_cnt, 0);

    // R3: out-of-range rejects
    base_cnt = nret;
    reject(BASE - 1); reject(BASE + 2048); reject(BASE + 4000);
    last_src = -1; resend(); quiet();
    chk(nret - base_cnt == 0, "R3 ignored reject", nret - base_cnt, 0);

    // R7: stall
    base_cnt = nret; retry_ready_i = 1'b0;
    reject(BASE + 300); last_src = -1; resend(); repeat (10) tick();
    chk(retry_valid_o && retry_src_o == 11'd300, "R7 stalled retry", int'(retry_src_o), 300);
    retry_ready_i = 1'b1; quiet();
    chk(nret - base_cnt == 1, "R7 single retry", nret - base_cnt, 1);

    // R8: reject during walk, behind and ahead
    base_cnt = nret; retry_ready_i = 1'b0;
    reject(BASE + 320); reject(BASE + 330); reject(BASE + 1400);
    last_src = -1; resend(); repeat (10) tick();
    chk(retry_src_o == 11'd320, "R8 walk position", int'(retry_src_o), 320);
    reject(BASE + 70); reject(BASE + 1500);
    retry_ready_i = 1'b1; quiet();
    chk(nret - base_cnt == 4, "R8 ahead replayed", nret - base_cnt, 4);
    chk(mb[70], "R8 behind waits", int'(mb[70]), 1);
    base_cnt = nret; last_src = -1; resend(); quiet();
    chk(nret - base_cnt == 1, "R8 behind on next replay", nret - base_cnt, 1);

    // R9: held replay request
    base_cnt = nret; retry_ready_i = 1'b0;
    reject(BASE + 600); reject(BASE + 900);
    last_src = -1; resend(); repeat (5) tick();
    resend(); reject(BASE + 10);
    retry_ready_i = 1'b1; quiet();
    chk(nret - base_cnt == 3, "R9 held request rescans", nret - base_cnt, 3);

    // R10: reset discards records
    base_cnt = nret;
    reject(BASE + 50); reject(BASE + 51);
    rst_n = 1'b0; tick(); tick();
    chk(!retry_valid_o, "R10 valid in reset", int'(retry_valid_o), 0);
    for (int i = 0; i < 2048; i++) mb[i] = 0;
    rst_n = 1'b1; tick();
    last_src = -1; resend(); quiet();
    chk(nret - base_cnt == 0, "R10 cleared", nret - base_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule